// File: doc/BRIEF.md
# Byte-Aliased General Register File

This block is the architectural register storage of a classic 16-bit processor core. It holds thirteen 16-bit registers: four data registers (accumulator, base, count, data), four pointer and index registers (stack pointer, base pointer, source index, destination index), four segment registers (code, data, extra, stack) and the instruction pointer. Two combinational read ports and one clocked write port serve the decode and execute stages.

Each port carries a register selector and a size selector. A data register can be reached as a full word, as its low byte (bits 7:0) or as its high byte (bits 15:8). For example, after a word write of 16'h1234 the high byte reads back as 8'h12 and the low byte as 8'h34. All other registers take only word access. A request that breaks this rule raises the port's error output and changes nothing.

Top module: `gpr_bank`

## Requirements
- R1: While rst_n is low, and after it is released, every register reads 16'h0000 until it is written.
- R2: A word write (size 2'b00) loads all 16 bits of wdata into the selected register at the rising clock edge.
- R3: A low-byte write (size 2'b01) to a data register (selector 0 to 3) copies wdata[7:0] into bits 7:0 and leaves bits 15:8 unchanged.
- R4: A high-byte write (size 2'b10) to a data register copies wdata[7:0] into bits 15:8 and leaves bits 7:0 unchanged.
- R5: A byte read returns the selected half in bits 7:0 of the read data with zeros in bits 15:8. The low half is bits 7:0 of the register and the high half is bits 15:8.
- R6: A byte-size request to a word-only register (selectors 4 to 12: 4 to 7 pointer and index, 8 to 11 segment, 12 instruction pointer) raises that port's error output. A read then returns zero, and a write leaves every register unchanged.
- R7: A read of the register being written in the same cycle returns the value held before that write.
- R8: Selectors 13 to 15 and size code 2'b11 are illegal on every port. They raise the error output, return zero on reads and block writes.
- R9: The two read ports decode independently and may address any register at any size at the same time.
- R10: With we low no register changes and werr stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| we | input | 1 | Write request |
| wsel | input | 4 | Write register selector |
| wsize | input | 2 | Write size: 00 word, 01 low byte, 10 high byte |
| wdata | input | 16 | Write data; byte writes take bits 7:0 |
| werr | output | 1 | Write request is illegal and was dropped |
| rsel_a | input | 4 | Read port A selector |
| rsize_a | input | 2 | Read port A size |
| rdata_a | output | 16 | Read port A data, bytes zero-extended |
| rerr_a | output | 1 | Read port A request is illegal |
| rsel_b | input | 4 | Read port B selector |
| rsize_b | input | 2 | Read port B size |
| rdata_b | output | 16 | Read port B data, bytes zero-extended |
| rerr_b | output | 1 | Read port B request is illegal |

## Verification
A corrupted register, or a byte write that spills into the wrong half, stays hidden until some port reads that register. The bench therefore reads through both ports on every cycle and keeps the register choice moving, so a wrong value shows up within a few cycles of the faulty edge. A write-enable fault on a dropped illegal request shows one cycle later, when the target reads back changed. An error-flag fault shows at once, in the same cycle as the request.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  localparam logic [1:0] SZ_WORD = 2'b00;
  localparam logic [1:0] SZ_LO   = 2'b01;
  localparam logic [1:0] SZ_HI   = 2'b10;
endpackage

// File: rtl/gpr_legal.sv
module gpr_legal #(
  parameter int NREG  = 13,
  parameter int NDATA = 4,
  parameter int SELW  = 4
) (
  input  logic [SELW-1:0] sel,
  input  logic [1:0]      size,
  output logic            illegal
);
  import gpr_pkg::*;
  logic in_range, byte_req, bad_size, word_only;

  always_comb begin
    in_range  = (int'(sel) < NREG);
    byte_req  = (size == SZ_LO) || (size == SZ_HI);
    bad_size  = (size == 2'b11);
    word_only = (int'(sel) >= NDATA);
    illegal   = !in_range || bad_size || (byte_req && word_only);
  end
endmodule

// File: rtl/gpr_rd_mux.sv
module gpr_rd_mux #(
  parameter int NREG  = 13,
  parameter int NDATA = 4,
  parameter int DW    = 16,
  parameter int SELW  = 4
) (
  input  logic [NREG-1:0][DW-1:0] regs,
  input  logic [SELW-1:0]         sel,
  input  logic [1:0]              size,
  output logic [DW-1:0]           rdata,
  output logic                    rerr
);
  import gpr_pkg::*;
  localparam int HW = DW / 2;
  logic [DW-1:0] word;
  logic          illegal;

  gpr_legal #(.NREG(NREG), .NDATA(NDATA), .SELW(SELW)) u_legal (
    .sel(sel), .size(size), .illegal(illegal)
  );

  always_comb begin
    word = '0;
    for (int i = 0; i < NREG; i++) begin
      if (sel == SELW'(i)) word = regs[i];
    end
  end

  always_comb begin
    rdata = '0;
    if (!illegal) begin
      unique case (size)
        SZ_LO:   rdata = {{HW{1'b0}}, word[HW-1:0]};
        SZ_HI:   rdata = {{HW{1'b0}}, word[DW-1:HW]};
        default: rdata = word;
      endcase
    end
  end

  assign rerr = illegal;
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int DW    = 16,
  parameter int NDATA = 4,
  parameter int NPTR  = 4,
  parameter int NSEG  = 4,
  localparam int NREG = NDATA + NPTR + NSEG + 1,
  localparam int SELW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            we,
  input  logic [SELW-1:0] wsel,
  input  logic [1:0]      wsize,
  input  logic [DW-1:0]   wdata,
  output logic            werr,
  input  logic [SELW-1:0] rsel_a,
  input  logic [1:0]      rsize_a,
  output logic [DW-1:0]   rdata_a,
  output logic            rerr_a,
  input  logic [SELW-1:0] rsel_b,
  input  logic [1:0]      rsize_b,
  output logic [DW-1:0]   rdata_b,
  output logic            rerr_b
);
  import gpr_pkg::*;
  localparam int HW = DW / 2;

  logic [NREG-1:0][DW-1:0] regs_q;
  logic                    wr_illegal;

  gpr_legal #(.NREG(NREG), .NDATA(NDATA), .SELW(SELW)) u_wr_legal (
    .sel(wsel), .size(wsize), .illegal(wr_illegal)
  );

  assign werr = we && wr_illegal;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic          en;
    logic [DW-1:0] d;
    logic [DW-1:0] q;

    always_comb begin
      en = we && !wr_illegal && (wsel == SELW'(i));
      unique case (wsize)
        SZ_LO:   d = {q[DW-1:HW], wdata[HW-1:0]};
        SZ_HI:   d = {wdata[HW-1:0], q[HW-1:0]};
        default: d = wdata;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
    end

    assign regs_q[i] = q;
  end

  gpr_rd_mux #(.NREG(NREG), .NDATA(NDATA), .DW(DW), .SELW(SELW)) u_rd_a (
    .regs(regs_q), .sel(rsel_a), .size(rsize_a), .rdata(rdata_a), .rerr(rerr_a)
  );

  gpr_rd_mux #(.NREG(NREG), .NDATA(NDATA), .DW(DW), .SELW(SELW)) u_rd_b (
    .regs(regs_q), .sel(rsel_b), .size(rsize_b), .rdata(rdata_b), .rerr(rerr_b)
  );
endmodule

// File: rtl/gpr_bank_sva.sv
module gpr_bank_sva #(
  parameter int DW   = 16,
  parameter int NREG = 13,
  parameter int SELW = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    we,
  input logic [SELW-1:0]         wsel,
  input logic [1:0]              wsize,
  input logic [DW-1:0]           wdata,
  input logic                    werr,
  input logic [1:0]              rsize_a,
  input logic [DW-1:0]           rdata_a,
  input logic                    rerr_a,
  input logic [NREG-1:0][DW-1:0] regs_q
);
  localparam int HW = DW / 2;
  logic          wr_ok;
  logic [DW-1:0] tgt_now;

  assign wr_ok = we && !werr && (int'(wsel) < NREG);

  always_comb begin
    tgt_now = '0;
    for (int i = 0; i < NREG; i++) begin
      if (wsel == SELW'(i)) tgt_now = regs_q[i];
    end
  end

  // R2
  a_r2_word_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && wsize == 2'b00) |=> (regs_q[$past(wsel)] == $past(wdata)));
  // R3
  a_r3_low_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && wsize == 2'b01) |=> (regs_q[$past(wsel)][DW-1:HW] == $past(tgt_now[DW-1:HW])));
  // R4
  a_r4_high_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ok && wsize == 2'b10) |=> (regs_q[$past(wsel)][HW-1:0] == $past(tgt_now[HW-1:0])));
  // R5
  a_r5_byte_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (!rerr_a && rsize_a != 2'b00) |-> (rdata_a[DW-1:HW] == '0));
  // R6, R8
  a_r6_dropped_write: assert property (@(posedge clk) disable iff (!rst_n)
    werr |=> $stable(regs_q));
  // R10
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(regs_q));
  // R10
  a_r10_no_err_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !we |-> !werr);
endmodule

bind gpr_bank gpr_bank_sva #(.DW(DW), .NREG(NREG), .SELW(SELW)) u_sva (
  .clk(clk), .rst_n(rst_n), .we(we), .wsel(wsel), .wsize(wsize), .wdata(wdata),
  .werr(werr), .rsize_a(rsize_a), .rdata_a(rdata_a), .rerr_a(rerr_a),
  .regs_q(regs_q)
);

// File: tb/gpr_bank_tb.sv
`timescale 1ns/1ps
module gpr_bank_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        we;
  logic [3:0]  wsel, rsel_a, rsel_b;
  logic [1:0]  wsize, rsize_a, rsize_b;
  logic [15:0] wdata, rdata_a, rdata_b;
  logic        werr, rerr_a, rerr_b;

  int total = 0;
  int bad = 0;
  int unsigned model [13];

  always #5 clk = ~clk;

  gpr_bank u_dut (
    .clk(clk), .rst_n(rst_n), .we(we), .wsel(wsel), .wsize(wsize), .wdata(wdata),
    .werr(werr), .rsel_a(rsel_a), .rsize_a(rsize_a), .rdata_a(rdata_a), .rerr_a(rerr_a),
    .rsel_b(rsel_b), .rsize_b(rsize_b), .rdata_b(rdata_b), .rerr_b(rerr_b)
  );

  function automatic bit legal(int sel, int size);
    if (sel > 12 || size == 3) return 0;
    if (size != 0 && sel >= 4) return 0;
    return 1;
  endfunction

  function automatic int exp_rd(int sel, int size);
    if (!legal(sel, size)) return 0;
    if (size == 1) return model[sel] & 'hFF;
    if (size == 2) return (model[sel] >> 8) & 'hFF;
    return model[sel];
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit w, int ws, int wz, int wd,
                      int ra, int za, int rb, int zb);
    @(negedge clk);
    we = w; wsel = 4'(ws); wsize = 2'(wz); wdata = 16'(wd);
    rsel_a = 4'(ra); rsize_a = 2'(za); rsel_b = 4'(rb); rsize_b = 2'(zb);
    #2;
    chk(tag, "rdata_a", int'(rdata_a), exp_rd(ra, za));
    chk(tag, "rerr_a", int'(rerr_a), int'(!legal(ra, za)));
    chk(tag, "rdata_b", int'(rdata_b), exp_rd(rb, zb));
    chk(tag, "rerr_b", int'(rerr_b), int'(!legal(rb, zb)));
    chk(tag, "werr", int'(werr), int'(w && !legal(ws, wz)));
    @(posedge clk);
    if (w && legal(ws, wz)) begin
      if (wz == 0)      model[ws] = wd & 'hFFFF;
      else if (wz == 1) model[ws] = (model[ws] & 'hFF00) | (wd & 'hFF);
      else              model[ws] = (model[ws] & 'h00FF) | ((wd & 'hFF) << 8);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 13; i++) model[i] = 0;
    repeat (3) @(negedge clk);
    // R1: all registers read zero while reset is held
    for (int i = 0; i < 13; i++) begin
      rsel_a = 4'(i); rsize_a = 2'b00;
      #1 chk("R1", "in reset", int'(rdata_a), 0);
    end
    rst_n = 1'b1;
  endtask

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; wsel = '0; wsize = '0; wdata = '0;
    rsel_a = '0; rsize_a = '0; rsel_b = '0; rsize_b = '0;
    do_reset();
    // R1: after release every register still reads zero
    for (int i = 0; i < 13; i++) step("R1", 0, 0, 0, 0, i, 0, 12 - i, 0);
    // R2: word write, read back both ways
    step("R2", 1, 0, 0, 'h1234, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 0, 0, 0, 0, 0);
    // R5: halves of 0x1234, zero-extended
    step("R5", 0, 0, 0, 0, 0, 2, 0, 1);
    // R3: low byte write keeps high byte
    step("R3", 1, 1, 0, 'h5566, 1, 0, 1, 0);
    step("R3", 1, 1, 1, 'hFFAB, 1, 0, 1, 1);
    step("R3", 0, 0, 0, 0, 1, 0, 1, 2);
    // R4: high byte write from wdata[7:0] keeps low byte
    step("R4", 1, 2, 0, 'h7788, 2, 0, 2, 0);
    step("R4", 1, 2, 2, 'h00CD, 2, 0, 2, 2);
    step("R4", 0, 0, 0, 0, 2, 0, 2, 1);
    // R6: byte access to word-only registers
    for (int i = 4; i <= 12; i++) step("R6", 1, i, 0, 'hA000 + i, i, 0, i, 1);
    step("R6", 1, 4, 1, 'h00EE, 4, 2, 4, 0);
    step("R6", 1, 12, 2, 'h00EE, 12, 1, 12, 0);
    step("R6", 0, 0, 0, 0, 4, 0, 12, 0);
    // R8: out-of-range selectors and reserved size
    step("R8", 1, 13, 0, 'hDEAD, 13, 0, 15, 0);
    step("R8", 1, 0, 3, 'hBEEF, 0, 3, 14, 1);
    step("R8", 0, 0, 0, 0, 0, 0, 13, 0);
    // R7: same-cycle read sees the old value
    step("R7", 1, 3, 0, 'h4242, 3, 0, 3, 1);
    step("R7", 1, 3, 2, 'h0099, 3, 0, 3, 2);
    step("R7", 0, 0, 0, 0, 3, 0, 3, 0);
    // R10: idle cycles
    for (int i = 0; i < 4; i++) step("R10", 0, i, 0, 'hFFFF, i, 0, i + 8, 0);
    // R9: mixed random traffic on both ports
    for (int n = 0; n < 400; n++)
      step("R9", bit'($urandom_range(0, 1)), $urandom_range(0, 15), $urandom_range(0, 3),
           $urandom_range(0, 'hFFFF), $urandom_range(0, 15), $urandom_range(0, 3),
           $urandom_range(0, 15), $urandom_range(0, 3));
    // R1: reset mid-run clears everything
    do_reset();
    for (int i = 0; i < 13; i++) step("R1", 0, 0, 0, 0, i, 0, i, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule